// File: doc/BRIEF.md
# Lane Reversal Configuration Controller

This block is the downstream-port side of the lane-numbering step in serial link configuration. Once training is enabled, it waits in a lane-number wait state for a minimum dwell time. It leaves that state when the link partner reports ready and the lane numbers it receives are either in order or reversed. In the accept state it decides whether the lanes are reversed. On the next cycle it moves to the configuration-complete state, with no added delay.

The block drives two lane maps, one for the transmit direction and one for the receive direction. Each map is the automatic reversal decision XORed with a manual flip setting for that direction. The manual flip settings are sampled only while training is disabled. A wait-state timeout models the partner giving up: if the timeout expires, or if the partner drops out, the block falls back to Detect and the link is not established.

Top module: `lane_cfg_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after training enable goes low, `state_o` is Detect (0) and `link_up_o` is 0. The state encoding is Detect=0, lane-number wait=1, lane-number accept=2, configuration complete=3. From Detect with training enabled, the next cycle is wait.
- R2: The block stays in wait for at least `WAIT_MIN_CYC`+1 cycles. It moves to accept on the first cycle after that dwell in which `partner_ready` is high and the lane order is valid.
- R3: After `WAIT_TMO_CYC` cycles in wait without advancing, the next state is Detect.
- R4: Accept lasts exactly one cycle. It is followed by configuration complete, or by Detect when the partner drops out or the lane order is invalid.
- R5: The lane order is in order when every lane i reports number i. It is reversed when lane 0 reports N-1 and lane N-1 reports 0. Any other pattern never leaves wait, so the timeout (R3) applies. Lane i's number sits at bits [i*LW +: LW] of `rx_lane_num`.
- R6: Each map entry at bits [i*LW +: LW] gives the physical lane for logical lane i. The entry is i when the direction is not flipped and N-1-i when it is.
- R7: The transmit flip is the automatic reversal XOR the captured transmit request. The receive flip is the automatic reversal XOR the captured receive request. The two directions are independent.
- R8: The flip requests are captured on every cycle that training enable is low. Changes while training is enabled, including on the cycle it rises, have no effect.
- R9: `partner_drop` high in wait, accept or complete sends the block to Detect on the next cycle.
- R10: `link_up_o` is high exactly in configuration complete. While it stays high, both maps hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_en | input | 1 | Training enable |
| rx_lane_num | input | NUM_LANES*LW | Received lane number per physical lane |
| partner_ready | input | 1 | Link partner ready to advance |
| partner_drop | input | 1 | Link partner has left configuration |
| tx_flip_req | input | 1 | Manual transmit lane-flip request |
| rx_flip_req | input | 1 | Manual receive lane-flip request |
| state_o | output | 2 | Current state |
| tx_map_o | output | NUM_LANES*LW | Transmit logical-to-physical map |
| rx_map_o | output | NUM_LANES*LW | Receive logical-to-physical map |
| link_up_o | output | 1 | Configuration complete |

## Verification
On every cycle the assertions check several rules: the minimum wait dwell and the timeout bound; that accept never lasts beyond one cycle and is followed only by complete or Detect; that dropping training enable or a partner drop forces Detect; and that the maps do not move while the link is up. Only the bench scenarios can show the exact entry cycles. The same holds for the values of the forward, reversed and manually flipped maps, for the way automatic reversal and manual flips combine, and for flip requests changed during training being ignored until training is next disabled.

// File: rtl/lane_cfg_pkg.sv
`timescale 1ns/1ps
package lane_cfg_pkg;
    typedef enum logic [1:0] {
        ST_DETECT = 2'd0,
        ST_LN_WAIT = 2'd1,
        ST_LN_ACCEPT = 2'd2,
        ST_CFG_DONE = 2'd3
    } lcfg_state_e;
endpackage

// File: rtl/lane_cfg_order.sv
`timescale 1ns/1ps
module lane_cfg_order #(
    parameter int NUM_LANES = 4,
    parameter int LW = 2
) (
    input  logic [NUM_LANES*LW-1:0] rx_lane_num,
    output logic                    is_fwd,
    output logic                    is_rev
);
    logic [NUM_LANES-1:0] lane_match;

    // one compare per lane for the in-order pattern
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_cmp
        assign lane_match[i] = (rx_lane_num[i*LW +: LW] == LW'(i));
    end

    assign is_fwd = &lane_match;
    // reversal is judged by the two end lanes only
    assign is_rev = (rx_lane_num[0 +: LW] == LW'(NUM_LANES-1)) &&
                    (rx_lane_num[(NUM_LANES-1)*LW +: LW] == LW'(0));
endmodule

// File: rtl/lane_cfg_xbar.sv
`timescale 1ns/1ps
module lane_cfg_xbar #(
    parameter int NUM_LANES = 4,
    parameter int LW = 2
) (
    input  logic                    flip,
    output logic [NUM_LANES*LW-1:0] map_o
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_map
        assign map_o[i*LW +: LW] = flip ? LW'(NUM_LANES-1-i) : LW'(i);
    end
endmodule

// File: rtl/lane_cfg_ctrl.sv
`timescale 1ns/1ps
module lane_cfg_ctrl
    import lane_cfg_pkg::*;
#(
    parameter int NUM_LANES    = 4,
    parameter int WAIT_MIN_CYC = 200000,
    parameter int WAIT_TMO_CYC = 400000,
    localparam int LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    train_en,
    input  logic [NUM_LANES*LW-1:0] rx_lane_num,
    input  logic                    partner_ready,
    input  logic                    partner_drop,
    input  logic                    tx_flip_req,
    input  logic                    rx_flip_req,
    output logic [1:0]              state_o,
    output logic [NUM_LANES*LW-1:0] tx_map_o,
    output logic [NUM_LANES*LW-1:0] rx_map_o,
    output logic                    link_up_o
);
    localparam int CW = $clog2(WAIT_TMO_CYC + 1);

    typedef struct packed {
        lcfg_state_e     st;
        logic [CW-1:0]   cnt;
        logic            auto_rev;
        logic            tx_flip;
        logic            rx_flip;
    } regs_t;

    regs_t r_d, r_q;
    logic  ord_fwd, ord_rev;
    logic  min_done, tmo_hit;

    lane_cfg_order #(.NUM_LANES(NUM_LANES), .LW(LW)) u_order (
        .rx_lane_num (rx_lane_num),
        .is_fwd      (ord_fwd),
        .is_rev      (ord_rev)
    );

    assign min_done = (r_q.cnt >= CW'(WAIT_MIN_CYC));
    assign tmo_hit  = (r_q.cnt == CW'(WAIT_TMO_CYC - 1));

    always_comb begin
        r_d = r_q;
        r_d.cnt = (r_q.st == ST_LN_WAIT) ? r_q.cnt + 1'b1 : '0;
        if (!train_en) begin
            r_d.st       = ST_DETECT;
            r_d.cnt      = '0;
            r_d.auto_rev = 1'b0;
            r_d.tx_flip  = tx_flip_req;
            r_d.rx_flip  = rx_flip_req;
        end else begin
            unique case (r_q.st)
                ST_DETECT: begin
                    r_d.st       = ST_LN_WAIT;
                    r_d.auto_rev = 1'b0;
                end
                ST_LN_WAIT: begin
                    if (partner_drop)
                        r_d.st = ST_DETECT;
                    else if (min_done && partner_ready && (ord_fwd || ord_rev))
                        r_d.st = ST_LN_ACCEPT;
                    else if (tmo_hit)
                        r_d.st = ST_DETECT;
                end
                ST_LN_ACCEPT: begin
                    if (partner_drop) begin
                        r_d.st = ST_DETECT;
                    end else if (ord_fwd) begin
                        r_d.auto_rev = 1'b0;
                        r_d.st       = ST_CFG_DONE;
                    end else if (ord_rev) begin
                        r_d.auto_rev = 1'b1;
                        r_d.st       = ST_CFG_DONE;
                    end else begin
                        r_d.st = ST_DETECT;
                    end
                end
                ST_CFG_DONE: begin
                    if (partner_drop)
                        r_d.st = ST_DETECT;
                end
                default: r_d.st = ST_DETECT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_DETECT, cnt: '0, auto_rev: 1'b0, tx_flip: 1'b0, rx_flip: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    lane_cfg_xbar #(.NUM_LANES(NUM_LANES), .LW(LW)) u_tx_xbar (
        .flip  (r_q.auto_rev ^ r_q.tx_flip),
        .map_o (tx_map_o)
    );

    lane_cfg_xbar #(.NUM_LANES(NUM_LANES), .LW(LW)) u_rx_xbar (
        .flip  (r_q.auto_rev ^ r_q.rx_flip),
        .map_o (rx_map_o)
    );

    assign state_o   = r_q.st;
    assign link_up_o = (r_q.st == ST_CFG_DONE);
endmodule

// File: rtl/lane_cfg_ctrl_chk.sv
`timescale 1ns/1ps
module lane_cfg_ctrl_chk #(
    parameter int NUM_LANES    = 4,
    parameter int WAIT_MIN_CYC = 200000,
    parameter int WAIT_TMO_CYC = 400000,
    parameter int LW           = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    train_en,
    input logic                    partner_drop,
    input logic [1:0]              state_o,
    input logic [NUM_LANES*LW-1:0] tx_map_o,
    input logic [NUM_LANES*LW-1:0] rx_map_o,
    input logic                    link_up_o
);
    int unsigned wait_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_seen <= 0;
        else if (state_o == 2'd1)
            wait_seen <= wait_seen + 1;
        else
            wait_seen <= 0;
    end

    assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (wait_seen < WAIT_TMO_CYC));

    assert_min_dwell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (wait_seen > WAIT_MIN_CYC));

    assert_accept_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> (state_o == 2'd3 || state_o == 2'd0));

    assert_train_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !train_en |=> (state_o == 2'd0 && !link_up_o));

    assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (partner_drop && state_o != 2'd0) |=> (state_o == 2'd0));

    assert_map_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_o && $past(link_up_o)) |-> ($stable(tx_map_o) && $stable(rx_map_o)));

    assert_up_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> ($past(state_o) == 2'd2));
endmodule

bind lane_cfg_ctrl lane_cfg_ctrl_chk #(
    .NUM_LANES(NUM_LANES), .WAIT_MIN_CYC(WAIT_MIN_CYC),
    .WAIT_TMO_CYC(WAIT_TMO_CYC), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .train_en(train_en), .partner_drop(partner_drop),
    .state_o(state_o), .tx_map_o(tx_map_o), .rx_map_o(rx_map_o), .link_up_o(link_up_o)
);

// File: tb/lane_cfg_ctrl_test.sv
`timescale 1ns/1ps
module lane_cfg_ctrl_test;
    localparam int N   = 4;
    localparam int LW  = 2;
    localparam int MIN = 20;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_en = 1'b0;
    logic [N*LW-1:0] rx_lane_num = '0;
    logic partner_ready = 1'b0;
    logic partner_drop = 1'b0;
    logic tx_flip_req = 1'b0;
    logic rx_flip_req = 1'b0;
    logic [1:0] state_o;
    logic [N*LW-1:0] tx_map_o, rx_map_o;
    logic link_up_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int first_acc, first_done, first_det;

    localparam logic [N*LW-1:0] FWD_MAP = {2'd3, 2'd2, 2'd1, 2'd0};
    localparam logic [N*LW-1:0] REV_MAP = {2'd0, 2'd1, 2'd2, 2'd3};

    always #2.5 clk = ~clk;

    lane_cfg_ctrl #(.NUM_LANES(N), .WAIT_MIN_CYC(MIN), .WAIT_TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .train_en(train_en), .rx_lane_num(rx_lane_num),
        .partner_ready(partner_ready), .partner_drop(partner_drop),
        .tx_flip_req(tx_flip_req), .rx_flip_req(rx_flip_req),
        .state_o(state_o), .tx_map_o(tx_map_o), .rx_map_o(rx_map_o), .link_up_o(link_up_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        train_en = 1'b0;
        partner_drop = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
    endtask

    // raises training and records the first cycle index of each state
    task automatic train_watch(input int ncyc);
        first_acc = -1; first_done = -1; first_det = -1;
        train_en = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            @(posedge clk); #1;
            if (state_o == 2'd2 && first_acc < 0) first_acc = k;
            if (state_o == 2'd3 && first_done < 0) first_done = k;
            if (state_o == 2'd0 && first_det < 0) first_det = k;
        end
    endtask

    task automatic t_reset();
        chk(state_o == 2'd0, "R1 reset state", state_o, 0);
        chk(link_up_o == 1'b0, "R1 reset link", link_up_o, 0);
        chk(tx_map_o == FWD_MAP, "R6 reset tx map", tx_map_o, FWD_MAP);
    endtask

    task automatic t_forward();
        idle();
        rx_lane_num = FWD_MAP; partner_ready = 1'b1;
        train_watch(MIN + 3);
        chk(first_acc == MIN + 2, "R2 accept entry", first_acc, MIN + 2);
        chk(first_done == MIN + 3, "R4 complete entry", first_done, MIN + 3);
        chk(link_up_o == 1'b1, "R10 link up", link_up_o, 1);
        chk(tx_map_o == FWD_MAP && rx_map_o == FWD_MAP, "R5 forward maps", tx_map_o, FWD_MAP);
    endtask

    task automatic t_auto_rev();
        idle();
        rx_lane_num = REV_MAP; partner_ready = 1'b1;
        train_watch(MIN + 3);
        chk(first_done == MIN + 3, "R4 reversed complete", first_done, MIN + 3);
        chk(tx_map_o == REV_MAP, "R6 auto tx map", tx_map_o, REV_MAP);
        chk(rx_map_o == REV_MAP, "R6 auto rx map", rx_map_o, REV_MAP);
    endtask

    task automatic t_manual();
        idle();
        tx_flip_req = 1'b1; rx_flip_req = 1'b0;
        @(posedge clk); #1; @(negedge clk);
        rx_lane_num = FWD_MAP; partner_ready = 1'b1;
        train_watch(MIN + 3);
        chk(tx_map_o == REV_MAP, "R7 manual tx flip", tx_map_o, REV_MAP);
        chk(rx_map_o == FWD_MAP, "R7 rx unflipped", rx_map_o, FWD_MAP);
        idle();
        rx_lane_num = REV_MAP;
        train_watch(MIN + 3);
        chk(tx_map_o == FWD_MAP, "R7 xor tx", tx_map_o, FWD_MAP);
        chk(rx_map_o == REV_MAP, "R7 xor rx", rx_map_o, REV_MAP);
        idle();
        tx_flip_req = 1'b0;
        @(posedge clk); #1; @(negedge clk);
    endtask

    task automatic t_flip_ignored();
        idle();
        rx_lane_num = FWD_MAP; partner_ready = 1'b1;
        tx_flip_req = 1'b1; rx_flip_req = 1'b1;   // same edge as training rises
        train_watch(MIN + 3);
        chk(tx_map_o == FWD_MAP, "R8 tx change ignored", tx_map_o, FWD_MAP);
        chk(rx_map_o == FWD_MAP, "R8 rx change ignored", rx_map_o, FWD_MAP);
        idle();
        train_watch(MIN + 3);
        chk(tx_map_o == REV_MAP && rx_map_o == REV_MAP, "R8 captured when off", tx_map_o, REV_MAP);
        idle();
        tx_flip_req = 1'b0; rx_flip_req = 1'b0;
        @(posedge clk); #1; @(negedge clk);
    endtask

    task automatic t_timeout();
        idle();
        rx_lane_num = FWD_MAP; partner_ready = 1'b0;
        train_watch(TMO + 1);
        chk(first_det == TMO + 1, "R3 timeout to detect", first_det, TMO + 1);
        chk(first_acc == -1, "R3 no accept", first_acc, -1);
        @(posedge clk); #1;
        chk(state_o == 2'd1, "R1 retry wait", state_o, 1);
    endtask

    task automatic t_bad_order();
        idle();
        rx_lane_num = {2'd3, 2'd2, 2'd0, 2'd1}; partner_ready = 1'b1;
        train_watch(TMO + 1);
        chk(first_acc == -1, "R5 bad order stays", first_acc, -1);
        chk(first_det == TMO + 1, "R5 bad order timeout", first_det, TMO + 1);
    endtask

    task automatic t_late_ready();
        idle();
        rx_lane_num = FWD_MAP; partner_ready = 1'b0;
        train_watch(MIN + 10);
        @(negedge clk); partner_ready = 1'b1;
        @(posedge clk); #1;
        chk(state_o == 2'd2, "R2 late ready accept", state_o, 2);
        @(posedge clk); #1;
        chk(state_o == 2'd3, "R4 late ready complete", state_o, 3);
    endtask

    task automatic t_drop();
        idle();
        rx_lane_num = FWD_MAP; partner_ready = 1'b1;
        train_watch(MIN + 3);
        @(negedge clk); partner_drop = 1'b1;
        @(posedge clk); #1;
        chk(state_o == 2'd0, "R9 drop to detect", state_o, 0);
        chk(link_up_o == 1'b0, "R9 link lost", link_up_o, 0);
        @(negedge clk); partner_drop = 1'b0;
        @(posedge clk); #1;
        chk(state_o == 2'd1, "R9 retrain wait", state_o, 1);
    endtask

    task automatic t_train_off();
        idle();
        rx_lane_num = FWD_MAP; partner_ready = 1'b1;
        train_watch(MIN + 3);
        @(negedge clk); train_en = 1'b0;
        @(posedge clk); #1;
        chk(state_o == 2'd0, "R1 train off detect", state_o, 0);
        chk(link_up_o == 1'b0, "R10 train off link", link_up_o, 0);
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_forward();
        t_auto_rev();
        t_manual();
        t_flip_ignored();
        t_timeout();
        t_bad_order();
        t_late_ready();
        t_drop();
        t_train_off();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule